// File: doc/BRIEF.md
# Gate Fault Soft Turn-Off Sequencer

This block is the digital part of a power-switch gate driver. It takes the PWM gate command and the output of an overcurrent comparator. It drives a three-level gate select (full on, intermediate, off) and a clamp enable that holds the gate low against crosstalk. In normal operation the gate follows the PWM command.

Right after each turn-on the comparator is ignored for a programmable blanking time, so that switching transients cannot trip the protection. Once the switch is armed, a comparator trip overrides the PWM command. The gate then drops to the intermediate level for a programmable dwell time and only after that goes fully off. The fault flag is latched for the controller's communication link. The PWM input stays blocked until a clear command arrives while the PWM command is low.

Both times are counted in clock cycles. The dwell width bounds the whole protective sequence: at 200 MHz with the default 8-bit dwell, the switch is fully off in under 1.3 µs.

Top module: `softoff_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, gateSel is 2'b00 (off), clampEn is 1 and faultFlag is 0.
- R2: With no fault latched, gateSel becomes 2'b10 (on) two clock edges after pwmCmd is first sampled high. It returns to 2'b00 two edges after pwmCmd is sampled low.
- R3: The comparator is ignored while the gate is in its blanking time, which begins at turn-on. If ocTrip is held high from turn-on, the gate stays on for exactly blankCycles+2 cycles before leaving the on level.
- R4: Once blanking has ended, ocTrip sampled high at a clock edge moves gateSel off the on level at the next edge. That is two cycles (10 ns at 200 MHz), well inside 80 ns.
- R5: After a trip, gateSel is 2'b01 (intermediate) for exactly dwellCycles+1 cycles and then 2'b00. The dwell and blanking values are taken when their interval starts.
- R6: gateSel is never 2'b11, and during a fault it never goes straight from on to off.
- R7: From the edge at which ocTrip is sampled, the gate is off within dwellCycles+3 edges. With an 8-bit dwell this is at most 258 cycles (1.29 µs at 200 MHz), under 1.5 µs.
- R8: faultFlag rises when the intermediate level is entered. It stays high until it is cleared.
- R9: While faultFlag is high, pwmCmd has no effect and gateSel stays off. A clear takes effect only at an edge where clearReq is high and pwmCmd is low; faultFlag is then 0 after that edge. clearReq with pwmCmd high is ignored.
- R10: clampEn is 1 exactly when gateSel is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmCmd | input | 1 | PWM gate command |
| ocTrip | input | 1 | Overcurrent comparator output |
| clearReq | input | 1 | Fault clear command |
| blankCycles | input | BLANK_W | Blanking time after turn-on, in cycles |
| dwellCycles | input | DWELL_W | Intermediate-level dwell, in cycles |
| gateSel | output | 2 | Gate level: 00 off, 01 intermediate, 10 on |
| clampEn | output | 1 | Active clamp enable |
| faultFlag | output | 1 | Latched short-circuit fault |

## Verification
The hardest case to reach from the ports is a trip that lands on the last cycle of blanking, or on the first armed cycle, together with a clear that coincides with a rising PWM edge. A random trip pulse seldom hits those exact cycles. The stimulus therefore draws short blanking values and sparse one-cycle comparator pulses over many PWM episodes, so that trips fall at every offset from turn-on. Clear requests are issued at random with both PWM levels. Directed runs hold the comparator high from turn-on and use the largest dwell to measure the blanking length and the full turn-off budget.

// File: rtl/softoff_pkg.sv
`timescale 1ns/1ps
package softoff_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_ARMED,
    ST_SOFT,
    ST_LATCH
  } seqState_t;

  typedef struct packed {
    logic loadBlank;
    logic loadDwell;
  } seqStrobe_t;

  localparam logic [1:0] GATE_OFF = 2'b00;
  localparam logic [1:0] GATE_MID = 2'b01;
  localparam logic [1:0] GATE_ON  = 2'b10;
endpackage

// File: rtl/softoff_datapath.sv
`timescale 1ns/1ps
module softoff_datapath
  import softoff_pkg::*;
#(
  parameter int BLANK_W = 8,
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmCmd,
  input  logic               ocTrip,
  input  logic [BLANK_W-1:0] blankCycles,
  input  logic [DWELL_W-1:0] dwellCycles,
  input  seqStrobe_t         strobe,
  output logic               pwmQ,
  output logic               ocQ,
  output logic               cntZero
);
  localparam int CW = (BLANK_W > DWELL_W) ? BLANK_W : DWELL_W;

  logic [CW-1:0] cnt;

  // input capture and the shared interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmQ <= 1'b0;
      ocQ  <= 1'b0;
      cnt  <= '0;
    end else begin
      pwmQ <= pwmCmd;
      ocQ  <= ocTrip;
      if (strobe.loadBlank)
        cnt <= CW'(blankCycles);
      else if (strobe.loadDwell)
        cnt <= CW'(dwellCycles);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/softoff_ctrl.sv
`timescale 1ns/1ps
module softoff_ctrl
  import softoff_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmQ,
  input  logic       ocQ,
  input  logic       cntZero,
  input  logic       pwmCmd,
  input  logic       clearReq,
  output seqStrobe_t strobe,
  output logic [1:0] gateSel,
  output logic       clampEn,
  output logic       faultFlag
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (pwmQ) begin
        nextState        = ST_BLANK;
        strobe.loadBlank = 1'b1;
      end
      ST_BLANK: begin
        if (!pwmQ)        nextState = ST_IDLE;
        else if (cntZero) nextState = ST_ARMED;
      end
      ST_ARMED: begin
        // a trip wins over a simultaneous PWM turn-off
        if (ocQ) begin
          nextState        = ST_SOFT;
          strobe.loadDwell = 1'b1;
        end else if (!pwmQ) begin
          nextState = ST_IDLE;
        end
      end
      ST_SOFT:  if (cntZero) nextState = ST_LATCH;
      ST_LATCH: if (clearReq && !pwmCmd) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_BLANK, ST_ARMED: gateSel = GATE_ON;
      ST_SOFT:            gateSel = GATE_MID;
      default:            gateSel = GATE_OFF;
    endcase
  end

  assign clampEn   = (state == ST_IDLE) || (state == ST_LATCH);
  assign faultFlag = (state == ST_SOFT) || (state == ST_LATCH);
endmodule

// File: rtl/softoff_sequencer.sv
`timescale 1ns/1ps
module softoff_sequencer
  import softoff_pkg::*;
#(
  parameter int BLANK_W = 8,
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmCmd,
  input  logic               ocTrip,
  input  logic               clearReq,
  input  logic [BLANK_W-1:0] blankCycles,
  input  logic [DWELL_W-1:0] dwellCycles,
  output logic [1:0]         gateSel,
  output logic               clampEn,
  output logic               faultFlag
);
  seqStrobe_t strobe;
  logic pwmQ, ocQ, cntZero;

  softoff_datapath #(.BLANK_W(BLANK_W), .DWELL_W(DWELL_W)) dp (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .ocTrip(ocTrip),
    .blankCycles(blankCycles), .dwellCycles(dwellCycles),
    .strobe(strobe), .pwmQ(pwmQ), .ocQ(ocQ), .cntZero(cntZero)
  );

  softoff_ctrl ctl (
    .clk(clk), .rstN(rstN), .pwmQ(pwmQ), .ocQ(ocQ), .cntZero(cntZero),
    .pwmCmd(pwmCmd), .clearReq(clearReq), .strobe(strobe),
    .gateSel(gateSel), .clampEn(clampEn), .faultFlag(faultFlag)
  );
endmodule

// File: rtl/softoff_checker.sv
`timescale 1ns/1ps
module softoff_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pwmCmd,
  input logic       clearReq,
  input logic [1:0] gateSel,
  input logic       clampEn,
  input logic       faultFlag
);
  // R6
  legal_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateSel != 2'b11);

  // R6
  no_hard_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && gateSel == 2'b00) |-> $past(gateSel) != 2'b10);

  // R10
  clamp_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    clampEn == (gateSel == 2'b00));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clearReq) |=> faultFlag);

  // R9
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> gateSel != 2'b10);

  // R5
  mid_means_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateSel == 2'b01) |-> faultFlag);

  // R9
  clear_needs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && pwmCmd && gateSel == 2'b00) |=> faultFlag);
endmodule

bind softoff_sequencer softoff_checker chk (
  .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .clearReq(clearReq),
  .gateSel(gateSel), .clampEn(clampEn), .faultFlag(faultFlag)
);

// File: tb/softoff_sequencer_test.sv
`timescale 1ns/1ps
module softoff_sequencer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwmCmd = 1'b0, ocTrip = 1'b0, clearReq = 1'b0;
  logic [7:0] blankCycles = 8'd4, dwellCycles = 8'd6;
  logic [1:0] gateSel;
  logic       clampEn, faultFlag;

  int checks = 0, errors = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  softoff_sequencer uut (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .ocTrip(ocTrip),
    .clearReq(clearReq), .blankCycles(blankCycles), .dwellCycles(dwellCycles),
    .gateSel(gateSel), .clampEn(clampEn), .faultFlag(faultFlag)
  );

  always #2.5 clk = ~clk;

  // reference model of the requirements: 0 idle,1 blank,2 armed,3 soft,4 latched
  int refMode = 0;
  int refCnt = 0;
  bit refPq = 0, refOq = 0;

  function automatic logic [1:0] expGate(int m);
    if (m == 1 || m == 2) return 2'b10;
    if (m == 3) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expFault(int m);
    return (m == 3 || m == 4);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      refMode = 0; refCnt = 0; refPq = 0; refOq = 0;
    end else begin
      int nm;
      int ld;
      nm = refMode; ld = -1;
      case (refMode)
        0: if (refPq) begin nm = 1; ld = int'(blankCycles); end
        1: if (!refPq) nm = 0; else if (refCnt == 0) nm = 2;
        2: if (refOq) begin nm = 3; ld = int'(dwellCycles); end
           else if (!refPq) nm = 0;
        3: if (refCnt == 0) nm = 4;
        default: if (clearReq && !pwmCmd) nm = 0;
      endcase
      if (ld >= 0) refCnt = ld;
      else if (refCnt != 0) refCnt = refCnt - 1;
      refMode = nm;
      refPq = pwmCmd;
      refOq = ocTrip;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [1:0] prevGate = 2'b00;
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      check("R2,R5 gateSel vs model", gateSel, expGate(refMode));
      check("R10 clampEn", clampEn, (gateSel == 2'b00));
      check("R8 faultFlag", faultFlag, expFault(refMode));
      check("R6 no on-to-off in fault",
            (faultFlag && gateSel == 2'b00 && prevGate == 2'b10), 0);
    end
    prevGate = gateSel;
  end

  task automatic sample();
    @(posedge clk); #1;
  endtask

  task automatic drive(logic p, logic o, logic c);
    @(negedge clk);
    pwmCmd = p; ocTrip = o; clearReq = c;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, firstMid, offAt, onCnt;
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 gateSel in reset", gateSel, 0);
    check("R1 clampEn in reset", clampEn, 1);
    check("R1 faultFlag in reset", faultFlag, 0);
    @(negedge clk) rstN = 1'b1;
    sample();
    check("R1 gateSel after reset", gateSel, 0);
    monOn = 1'b1;

    // R4 and R7: largest dwell, trip once armed
    blankCycles = 8'd2; dwellCycles = 8'd255;
    drive(1, 0, 0);
    repeat (10) sample();
    check("R2 on once commanded", gateSel, 2'b10);
    drive(1, 1, 0);
    firstMid = -1; offAt = -1; n = 0;
    while (offAt < 0 && n < 400) begin
      sample(); n++;
      if (firstMid < 0 && gateSel == 2'b01) firstMid = n;
      if (gateSel == 2'b00) offAt = n;
    end
    check("R4 trip to intermediate latency", firstMid, 2);
    check("R7 trip to off cycles", offAt, 255 + 3);
    check("R7 within 1.5us budget", (offAt <= 300), 1);

    // R9: clear with pwm high is ignored
    drive(1, 0, 1);
    repeat (3) sample();
    check("R9 clear ignored while pwm high", faultFlag, 1);
    check("R9 gate stays off while latched", gateSel, 0);
    drive(0, 0, 1);
    sample();
    check("R9 clear accepted with pwm low", faultFlag, 0);
    drive(0, 0, 0);
    repeat (3) sample();

    // R3: comparator held from turn-on
    blankCycles = 8'd10; dwellCycles = 8'd3;
    drive(1, 1, 0);
    onCnt = 0; n = 0;
    while (gateSel != 2'b01 && n < 100) begin
      sample(); n++;
      if (gateSel == 2'b10) onCnt++;
    end
    check("R3 on time with comparator held", onCnt, 10 + 2);
    drive(0, 0, 0);
    repeat (6) sample();
    drive(0, 0, 1);
    drive(0, 0, 0);
    repeat (2) sample();
    check("R9 clean after clear", faultFlag, 0);

    // random episodes
    for (int ep = 0; ep < 300; ep++) begin
      int hi, lo;
      blankCycles = 8'($urandom % 12);
      dwellCycles = ($urandom % 10 == 0) ? 8'd255 : 8'($urandom % 20);
      hi = 1 + $urandom % 40;
      lo = 1 + $urandom % 8;
      for (int i = 0; i < hi; i++)
        drive(1, ($urandom % 20 == 0), ($urandom % 6 == 0));
      for (int i = 0; i < lo; i++)
        drive(0, ($urandom % 30 == 0), ($urandom % 4 == 0));
    end
    drive(0, 0, 0);
    repeat (300) sample();
    drive(0, 0, 1);
    drive(0, 0, 0);
    repeat (3) sample();
    check("R8,R9 final clear", faultFlag, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule